// File: doc/BRIEF.md
# Network Clock Reference Inserter

This block places network clock reference (NCR) timestamps into outgoing 188-byte transport packets, one byte per cycle. A free-running reference counter advances on each 27 MHz tick enable. Each start-of-frame pulse from the transmitter's jitter-free point copies the counter into a capture register. A programmable timer raises a request at a nominal 40 ms rate. Each request marks every stream as owing one NCR.

A packet that starts on a stream with an NCR owed has the last captured value written big-endian into its reference field, if the packet reports room. If there is no room, the packet passes unchanged and the NCR goes into the last bytes of that stream's next packet. A stream that owes an NCR and has nothing queued gets a packet built by the block that carries only the NCR. Repeated requests while an NCR is still owed cause no second insertion.

The control state machine has three states:
- IDLE: between packets.
- PASS: forwarding an input packet.
- GEN: emitting an NCR-only packet.

Its transitions are:
- IDLE to GEN, when an owing stream is idle. This takes priority.
- IDLE to PASS, when a start byte is accepted.
- PASS to IDLE, on the accepted byte 187.
- GEN to IDLE, after byte 187 is emitted.

Top module: `ncr_inserter`

## Requirements
- R1: The reference counter increments by one on each clock where `tick_27m` is high and holds otherwise; it resets to 0.
- R2: On each clock with `sof_pulse` high the capture register takes the counter value seen before that edge; an insertion uses the capture held when its packet starts.
- R3: The request timer pulses `ncr_req` for one cycle every P ticks, where P is the period in force; a write through `period_wr`/`period_val` loads P and restarts the count from zero.
- R4: After reset the period is `DEF_PERIOD` ticks (default 1,080,000 = 40 ms at 27 MHz), so the first pulse comes on the DEF_PERIOD-th tick.
- R5: A request sets the owed flag of every stream on the next cycle (`ncr_pending`, bit s for stream s); a request while a flag is still set yields only one insertion for that stream.
- R6: A packet starting on an owing stream with `in_room` high leaves with the capture written most-significant byte first into bytes FIELD_OFS..FIELD_OFS+3 (default 6..9, byte 0 = first), and the flag clears.
- R7: A packet starting on an owing stream with `in_room` low passes unchanged; the next packet of that stream, whatever its `in_room`, carries the capture in bytes 184..187 and clears the flag.
- R8: When a stream owes an NCR and its `stream_queued` bit is low, the block emits a 188-byte packet on that stream: 0x47 at byte 0, the capture at bytes FIELD_OFS..FIELD_OFS+3, 0xFF elsewhere. The lowest-numbered such stream goes first, and `in_ready` is low while it is emitted.
- R9: Packets with no insertion pass unchanged one cycle after each byte is accepted, with `out_sop` on byte 0, `out_eop` on byte 187 and `out_stream` held for the packet.
- R10: A byte accepted between packets without `in_sop` is dropped and produces no output.
- R11: After reset `out_valid`, `ncr_req` and `ncr_pending` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_27m | input | 1 | 27 MHz count enable |
| sof_pulse | input | 1 | Start-of-frame strobe from the transmitter |
| period_wr | input | 1 | Load a new request period |
| period_val | input | PER_W | Request period in ticks |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | Input byte is byte 0 of a packet |
| in_stream | input | SID_W | Stream of the input packet |
| in_room | input | 1 | Input packet has a free reference field |
| in_data | input | 8 | Input byte |
| stream_queued | input | NUM_STREAMS | Per stream: packets waiting upstream |
| in_ready | output | 1 | Input byte accepted this cycle |
| out_valid | output | 1 | Output byte valid |
| out_sop | output | 1 | Output byte 0 |
| out_eop | output | 1 | Output byte 187 |
| out_stream | output | SID_W | Stream of the output packet |
| out_data | output | 8 | Output byte |
| ncr_req | output | 1 | Periodic request pulse |
| ncr_pending | output | NUM_STREAMS | Per-stream owed flags |

## Verification
A wrong owed or deferred flag shows up within one packet of the affected stream. The symptoms are a reference field missing or doubled, a timestamp in the tail instead of the field, or an NCR-only packet that should not exist. A stuck or misaligned position counter corrupts the framing markers within 188 cycles. A counter or capture fault shows up as a wrong field value in the first stamped packet after the fault. A timer fault shows as a wrong spacing of `ncr_req`, measured from one pulse to the next.

// File: rtl/ncr_pkg.sv
package ncr_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_PASS, ST_GEN} mux_state_e;
    typedef enum logic [1:0] {INS_NONE, INS_FIELD, INS_TAIL} ins_mode_e;
    localparam int          PKT_LEN    = 188;
    localparam logic [7:0]  SYNC_BYTE  = 8'h47;
    localparam logic [7:0]  STUFF_BYTE = 8'hFF;
endpackage

// File: rtl/ncr_clock_sampler.sv
module ncr_clock_sampler #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             sof,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cap_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cap_q <= '0;
        end else begin
            if (tick) cnt_q <= cnt_q + CNT_W'(1);
            if (sof)  cap_q <= cnt_q;
        end
    end

    assign cnt_o = cnt_q;
    assign cap_o = cap_q;
endmodule

// File: rtl/ncr_req_timer.sv
module ncr_req_timer #(
    parameter int PER_W      = 24,
    parameter int DEF_PERIOD = 1080000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             per_wr,
    input  logic [PER_W-1:0] per_val,
    output logic             req_o
);
    logic [PER_W-1:0] period_q;
    logic [PER_W-1:0] tmr_q;
    logic [PER_W:0]   tmr_nxt;
    logic             req_q;

    always_comb tmr_nxt = {1'b0, tmr_q} + (PER_W+1)'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= PER_W'(DEF_PERIOD);
            tmr_q    <= '0;
            req_q    <= 1'b0;
        end else begin
            req_q <= 1'b0;
            if (per_wr) begin
                period_q <= per_val;
                tmr_q    <= '0;
            end else if (tick) begin
                if (tmr_nxt >= {1'b0, period_q}) begin
                    tmr_q <= '0;
                    req_q <= 1'b1;
                end else begin
                    tmr_q <= tmr_nxt[PER_W-1:0];
                end
            end
        end
    end

    assign req_o = req_q;
endmodule

// File: rtl/ncr_stream_flags.sv
module ncr_stream_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] defer_set,
    output logic [N-1:0] pend_o,
    output logic [N-1:0] defer_o
);
    logic [N-1:0] pend_q;
    logic [N-1:0] defer_q;

    for (genvar g = 0; g < N; g++) begin : g_stream
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q[g]  <= 1'b0;
                defer_q[g] <= 1'b0;
            end else begin
                if (req)         pend_q[g] <= 1'b1;
                else if (clr[g]) pend_q[g] <= 1'b0;
                if (clr[g])            defer_q[g] <= 1'b0;
                else if (defer_set[g]) defer_q[g] <= 1'b1;
            end
        end
    end

    assign pend_o  = pend_q;
    assign defer_o = defer_q;
endmodule

// File: rtl/ncr_pkt_mux.sv
module ncr_pkt_mux
    import ncr_pkg::*;
#(
    parameter int N         = 2,
    parameter int SID_W     = 1,
    parameter int NCR_W     = 32,
    parameter int FIELD_OFS = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCR_W-1:0] cap,
    input  logic [N-1:0]     pend,
    input  logic [N-1:0]     defer,
    input  logic [N-1:0]     queued,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic [SID_W-1:0] in_stream,
    input  logic             in_room,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output logic [N-1:0]     clr,
    output logic [N-1:0]     defer_set,
    output logic             out_valid,
    output logic             out_sop,
    output logic             out_eop,
    output logic [SID_W-1:0] out_stream,
    output logic [7:0]       out_data,
    output mux_state_e       state_o
);
    localparam int NB       = NCR_W / 8;
    localparam int POS_W    = $clog2(PKT_LEN);
    localparam int TAIL_OFS = PKT_LEN - NB;
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(PKT_LEN - 1);

    mux_state_e       state_q, state_d;
    ins_mode_e        mode_q, mode_d;
    logic [POS_W-1:0] pos_q;
    logic [NCR_W-1:0] ncr_q;
    logic [SID_W-1:0] sid_q;
    logic             gen_want;
    logic [SID_W-1:0] gen_sel;
    logic             start_pass, start_gen;
    logic             ready_c;
    logic [7:0]       pass_byte, gen_byte;

    function automatic logic [7:0] ncr_byte(input logic [NCR_W-1:0] v, input int k);
        return v[(NCR_W - 1 - 8 * k) -: 8];
    endfunction

    // lowest-numbered idle stream that still owes a timestamp
    always_comb begin
        gen_want = 1'b0;
        gen_sel  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i] && !queued[i]) begin
                gen_want = 1'b1;
                gen_sel  = SID_W'(i);
            end
        end
    end

    // next state and per-packet decisions
    always_comb begin
        state_d    = state_q;
        mode_d     = INS_NONE;
        clr        = '0;
        defer_set  = '0;
        ready_c    = 1'b0;
        start_pass = 1'b0;
        start_gen  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (gen_want) begin
                    state_d      = ST_GEN;
                    start_gen    = 1'b1;
                    clr[gen_sel] = 1'b1;
                end else begin
                    ready_c = 1'b1;
                    if (in_valid && in_sop) begin
                        state_d    = ST_PASS;
                        start_pass = 1'b1;
                        if (pend[in_stream]) begin
                            if (defer[in_stream]) begin
                                mode_d         = INS_TAIL;
                                clr[in_stream] = 1'b1;
                            end else if (in_room) begin
                                mode_d         = INS_FIELD;
                                clr[in_stream] = 1'b1;
                            end else begin
                                defer_set[in_stream] = 1'b1;
                            end
                        end
                    end
                end
            end
            ST_PASS: begin
                ready_c = 1'b1;
                if (in_valid && pos_q == LAST_POS) state_d = ST_IDLE;
            end
            ST_GEN: begin
                if (pos_q == LAST_POS) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // byte substitution
    always_comb begin
        int p;
        p         = int'(pos_q);
        pass_byte = in_data;
        if (mode_q == INS_FIELD && p >= FIELD_OFS && p < FIELD_OFS + NB)
            pass_byte = ncr_byte(ncr_q, p - FIELD_OFS);
        else if (mode_q == INS_TAIL && p >= TAIL_OFS)
            pass_byte = ncr_byte(ncr_q, p - TAIL_OFS);
        if (p == 0)
            gen_byte = SYNC_BYTE;
        else if (p >= FIELD_OFS && p < FIELD_OFS + NB)
            gen_byte = ncr_byte(ncr_q, p - FIELD_OFS);
        else
            gen_byte = STUFF_BYTE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // packet context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q  <= '0;
            mode_q <= INS_NONE;
            ncr_q  <= '0;
            sid_q  <= '0;
        end else if (start_gen) begin
            pos_q  <= '0;
            mode_q <= INS_FIELD;
            ncr_q  <= cap;
            sid_q  <= gen_sel;
        end else if (start_pass) begin
            pos_q  <= POS_W'(1);
            mode_q <= mode_d;
            ncr_q  <= cap;
            sid_q  <= in_stream;
        end else if ((state_q == ST_PASS && in_valid) || state_q == ST_GEN) begin
            pos_q  <= pos_q + POS_W'(1);
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_sop    <= 1'b0;
            out_eop    <= 1'b0;
            out_stream <= '0;
            out_data   <= '0;
        end else begin
            out_valid <= 1'b0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_pass) begin
                        out_valid  <= 1'b1;
                        out_sop    <= 1'b1;
                        out_data   <= in_data;
                        out_stream <= in_stream;
                    end
                end
                ST_PASS: begin
                    if (in_valid) begin
                        out_valid  <= 1'b1;
                        out_eop    <= (pos_q == LAST_POS);
                        out_data   <= pass_byte;
                        out_stream <= sid_q;
                    end
                end
                ST_GEN: begin
                    out_valid  <= 1'b1;
                    out_sop    <= (pos_q == '0);
                    out_eop    <= (pos_q == LAST_POS);
                    out_data   <= gen_byte;
                    out_stream <= sid_q;
                end
                default: ;
            endcase
        end
    end

    assign in_ready = ready_c;
    assign state_o  = state_q;
endmodule

// File: rtl/ncr_inserter.sv
module ncr_inserter
    import ncr_pkg::*;
#(
    parameter int NUM_STREAMS = 2,
    parameter int NCR_W       = 32,
    parameter int PER_W       = 24,
    parameter int DEF_PERIOD  = 1080000,
    parameter int FIELD_OFS   = 6,
    localparam int SID_W      = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick_27m,
    input  logic                   sof_pulse,
    input  logic                   period_wr,
    input  logic [PER_W-1:0]       period_val,
    input  logic                   in_valid,
    input  logic                   in_sop,
    input  logic [SID_W-1:0]       in_stream,
    input  logic                   in_room,
    input  logic [7:0]             in_data,
    input  logic [NUM_STREAMS-1:0] stream_queued,
    output logic                   in_ready,
    output logic                   out_valid,
    output logic                   out_sop,
    output logic                   out_eop,
    output logic [SID_W-1:0]       out_stream,
    output logic [7:0]             out_data,
    output logic                   ncr_req,
    output logic [NUM_STREAMS-1:0] ncr_pending
);
    logic [NCR_W-1:0]       stamp_cnt;
    logic [NCR_W-1:0]       stamp_cap;
    logic [NUM_STREAMS-1:0] defer_flags;
    logic [NUM_STREAMS-1:0] flag_clr;
    logic [NUM_STREAMS-1:0] flag_defer;
    mux_state_e             fsm_state;

    ncr_clock_sampler #(.CNT_W(NCR_W)) u_sampler (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_27m),
        .sof   (sof_pulse),
        .cnt_o (stamp_cnt),
        .cap_o (stamp_cap)
    );

    ncr_req_timer #(.PER_W(PER_W), .DEF_PERIOD(DEF_PERIOD)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_27m),
        .per_wr  (period_wr),
        .per_val (period_val),
        .req_o   (ncr_req)
    );

    ncr_stream_flags #(.N(NUM_STREAMS)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (ncr_req),
        .clr       (flag_clr),
        .defer_set (flag_defer),
        .pend_o    (ncr_pending),
        .defer_o   (defer_flags)
    );

    ncr_pkt_mux #(
        .N         (NUM_STREAMS),
        .SID_W     (SID_W),
        .NCR_W     (NCR_W),
        .FIELD_OFS (FIELD_OFS)
    ) u_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap        (stamp_cap),
        .pend       (ncr_pending),
        .defer      (defer_flags),
        .queued     (stream_queued),
        .in_valid   (in_valid),
        .in_sop     (in_sop),
        .in_stream  (in_stream),
        .in_room    (in_room),
        .in_data    (in_data),
        .in_ready   (in_ready),
        .clr        (flag_clr),
        .defer_set  (flag_defer),
        .out_valid  (out_valid),
        .out_sop    (out_sop),
        .out_eop    (out_eop),
        .out_stream (out_stream),
        .out_data   (out_data),
        .state_o    (fsm_state)
    );
endmodule

// File: rtl/ncr_inserter_chk.sv
module ncr_inserter_chk
    import ncr_pkg::*;
#(
    parameter int N     = 2,
    parameter int SID_W = 1,
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic [CNT_W-1:0] cnt,
    input logic             ncr_req,
    input logic [N-1:0]     ncr_pending,
    input logic             in_valid,
    input logic             in_sop,
    input logic             in_ready,
    input mux_state_e       fsm_state,
    input logic             out_valid,
    input logic             out_sop,
    input logic             out_eop,
    input logic [SID_W-1:0] out_stream
);
    p_cnt_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));

    p_pend_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ncr_req |=> (&ncr_pending));

    p_sop_not_eop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_sop |-> (out_valid && !out_eop));

    p_eop_then_sop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_eop |=> (!out_valid || out_sop));

    p_stream_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_sop) |-> $stable(out_stream));

    p_idle_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_IDLE && in_ready && in_valid && !in_sop) |=> !out_valid);
endmodule

bind ncr_inserter ncr_inserter_chk #(
    .N     (NUM_STREAMS),
    .SID_W (SID_W),
    .CNT_W (NCR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick_27m),
    .cnt         (stamp_cnt),
    .ncr_req     (ncr_req),
    .ncr_pending (ncr_pending),
    .in_valid    (in_valid),
    .in_sop      (in_sop),
    .in_ready    (in_ready),
    .fsm_state   (fsm_state),
    .out_valid   (out_valid),
    .out_sop     (out_sop),
    .out_eop     (out_eop),
    .out_stream  (out_stream)
);

// File: tb/ncr_inserter_tb.sv
module ncr_inserter_tb;
    localparam int N    = 2;
    localparam int PW   = 24;
    localparam int FOFS = 6;
    localparam int PLEN = 188;
    localparam int DEFP = 60;
    localparam logic [1:0] M_NONE = 2'd0, M_FIELD = 2'd1, M_TAIL = 2'd2, M_GEN = 2'd3;

    // {fire, stream, room, mode[1:0], tick gap[2:0]}
    localparam logic [7:0] VECS [0:9] = '{
        {1'b0, 1'b0, 1'b1, M_NONE,  3'd0},
        {1'b1, 1'b0, 1'b1, M_FIELD, 3'd3},
        {1'b0, 1'b1, 1'b0, M_NONE,  3'd0},
        {1'b0, 1'b1, 1'b1, M_TAIL,  3'd2},
        {1'b0, 1'b0, 1'b1, M_NONE,  3'd0},
        {1'b1, 1'b1, 1'b0, M_NONE,  3'd0},
        {1'b1, 1'b1, 1'b1, M_TAIL,  3'd1},
        {1'b0, 1'b0, 1'b1, M_FIELD, 3'd0},
        {1'b0, 1'b0, 1'b1, M_NONE,  3'd0},
        {1'b0, 1'b1, 1'b1, M_NONE,  3'd4}
    };

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n, tick, sof, period_wr, in_valid, in_sop, in_room;
    logic [PW-1:0] period_val;
    logic [0:0]    in_stream, out_stream;
    logic [7:0]    in_data, out_data;
    logic [N-1:0]  queued, ncr_pending;
    logic          in_ready, out_valid, out_sop, out_eop, ncr_req;

    ncr_inserter #(.NUM_STREAMS(N), .NCR_W(32), .PER_W(PW), .DEF_PERIOD(DEFP), .FIELD_OFS(FOFS)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_27m(tick), .sof_pulse(sof),
        .period_wr(period_wr), .period_val(period_val),
        .in_valid(in_valid), .in_sop(in_sop), .in_stream(in_stream), .in_room(in_room),
        .in_data(in_data), .stream_queued(queued), .in_ready(in_ready),
        .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop),
        .out_stream(out_stream), .out_data(out_data),
        .ncr_req(ncr_req), .ncr_pending(ncr_pending)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] tb_cnt;
    logic [31:0] cap_exp;
    logic [7:0]  exp_pkt [PLEN];
    logic [7:0]  got [PLEN];
    int          got_n = 0;
    int          pkt_cnt = 0;
    logic [0:0]  got_sid = '0;
    bit          got_framing = 1'b0;

    // reference counter model (R1)
    always @(posedge clk) begin
        if (!rst_n)    tb_cnt <= '0;
        else if (tick) tb_cnt <= tb_cnt + 1;
    end

    // output monitor
    always @(negedge clk) begin
        if (out_valid) begin
            if (out_sop) begin
                got_n = 0;
                got_framing = 1'b1;
                got_sid = out_stream;
            end
            if (got_n < PLEN) got[got_n] = out_data;
            if (out_stream != got_sid) got_framing = 1'b0;
            if (out_eop) begin
                if (got_n != PLEN - 1) got_framing = 1'b0;
                pkt_cnt++;
            end else if (got_n >= PLEN - 1) begin
                got_framing = 1'b0;
            end
            got_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] dbyte(input int p, input int seed);
        return (p == 0) ? 8'h47 : 8'(p * 5 + seed * 11 + 1);
    endfunction

    task automatic build_exp(input logic [1:0] mode, input int seed);
        for (int p = 0; p < PLEN; p++) begin
            if (mode == M_GEN) exp_pkt[p] = (p == 0) ? 8'h47 : 8'hFF;
            else               exp_pkt[p] = dbyte(p, seed);
        end
        for (int k = 0; k < 4; k++) begin
            if (mode == M_FIELD || mode == M_GEN) exp_pkt[FOFS + k] = cap_exp[31 - 8*k -: 8];
            if (mode == M_TAIL) exp_pkt[PLEN - 4 + k] = cap_exp[31 - 8*k -: 8];
        end
    endtask

    task automatic wait_pkt(input int base, input string req);
        int n = 0;
        while (pkt_cnt <= base && n < 800) begin
            @(negedge clk);
            n++;
        end
        chk(pkt_cnt > base, req, "packet arrived", pkt_cnt, base + 1);
    endtask

    task automatic cmp_pkt(input string req, input logic [0:0] sid);
        int bad = -1;
        for (int p = PLEN - 1; p >= 0; p--) if (got[p] !== exp_pkt[p]) bad = p;
        chk(bad < 0, req, $sformatf("byte %0d", bad < 0 ? 0 : bad),
            bad < 0 ? 0 : got[bad], bad < 0 ? 0 : exp_pkt[bad]);
        chk(got_framing, "R9", "sop/eop framing", got_framing, 1);
        chk(got_sid == sid, req, "stream tag", got_sid, sid);
    endtask

    task automatic write_period(input logic [PW-1:0] v);
        period_val = v;
        period_wr  = 1'b1;
        @(negedge clk);
        period_wr  = 1'b0;
    endtask

    task automatic fire_req();
        int n = 0;
        write_period(2);
        while (!ncr_req && n < 50) begin
            @(negedge clk);
            n++;
        end
        write_period('1);
        @(negedge clk);
    endtask

    task automatic do_sof();
        sof = 1'b1;
        cap_exp = tb_cnt;
        @(negedge clk);
        sof = 1'b0;
    endtask

    task automatic run_vec(input bit fire, input logic [0:0] sid, input bit room,
                           input logic [1:0] mode, input int gap, input int seed,
                           input string req);
        int base;
        if (gap > 0) begin
            tick = 1'b0;
            repeat (gap) @(negedge clk);
            tick = 1'b1;
        end
        do_sof();
        if (fire) fire_req();
        build_exp(mode, seed);
        base = pkt_cnt;
        for (int p = 0; p < PLEN; p++) begin
            in_valid  = 1'b1;
            in_sop    = (p == 0);
            in_stream = sid;
            in_room   = room;
            in_data   = dbyte(p, seed);
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_sop   = 1'b0;
        wait_pkt(base, req);
        cmp_pkt(req, sid);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n, base;
        rst_n = 1'b0; tick = 1'b0; sof = 1'b0; period_wr = 1'b0; period_val = '0;
        in_valid = 1'b0; in_sop = 1'b0; in_stream = '0; in_room = 1'b0; in_data = '0;
        queued = '1;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(out_valid == 0, "R11", "out_valid", out_valid, 0);
        chk(in_ready == 1, "R11", "in_ready", in_ready, 1);
        chk(ncr_pending == 0, "R11", "pending", ncr_pending, 0);
        chk(ncr_req == 0, "R11", "ncr_req", ncr_req, 0);
        rst_n = 1'b1;
        tick  = 1'b1;

        // R4 default period
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!ncr_req && n < 200);
        chk(n == DEFP, "R4", "ticks to first request", n, DEFP);
        write_period('1);
        @(negedge clk);
        chk(ncr_pending == 2'b11, "R5", "all streams owe", ncr_pending, 2'b11);

        // R6 flush both streams through the field
        run_vec(1'b0, 1'b0, 1'b1, M_FIELD, 0, 20, "R6");
        run_vec(1'b0, 1'b1, 1'b1, M_FIELD, 0, 21, "R6");
        chk(ncr_pending == 2'b00, "R6", "flags cleared", ncr_pending, 0);

        // table of vectors: R2 R5 R6 R7 R9
        for (int v = 0; v < 10; v++) begin
            logic [1:0] md;
            md = VECS[v][4:3];
            run_vec(VECS[v][7], VECS[v][6], VECS[v][5], md, int'(VECS[v][2:0]), v,
                    md == M_FIELD ? "R6" : (md == M_TAIL ? "R7" : "R5"));
        end

        // R3 programmed period and restart
        write_period(7);
        n = 0;
        while (!ncr_req && n < 50) begin @(negedge clk); n++; end
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!ncr_req && n < 50);
        chk(n == 7, "R3", "request spacing", n, 7);
        write_period('1);
        @(negedge clk);
        // R7: deferred insertion ignores room on the following packet
        run_vec(1'b0, 1'b0, 1'b0, M_NONE, 0, 30, "R7");
        run_vec(1'b0, 1'b0, 1'b0, M_TAIL, 0, 31, "R7");
        run_vec(1'b0, 1'b1, 1'b1, M_FIELD, 0, 32, "R2");

        // R10 stray byte between packets
        in_valid = 1'b1; in_sop = 1'b0; in_data = 8'h5A;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk(out_valid == 0, "R10", "stray byte dropped", out_valid, 0);
        run_vec(1'b0, 1'b0, 1'b1, M_NONE, 0, 40, "R10");

        // R8 NCR-only packet for an idle stream
        queued = 2'b01;
        do_sof();
        base = pkt_cnt;
        fire_req();
        @(negedge clk);
        chk(in_ready == 0, "R8", "in_ready low while generating", in_ready, 0);
        build_exp(M_GEN, 0);
        wait_pkt(base, "R8");
        cmp_pkt("R8", 1'b1);
        chk(ncr_pending == 2'b01, "R8", "idle stream flag cleared", ncr_pending, 2'b01);
        queued = 2'b11;
        run_vec(1'b0, 1'b0, 1'b1, M_FIELD, 0, 50, "R6");

        // R8 lowest-numbered idle stream first
        queued = 2'b00;
        do_sof();
        base = pkt_cnt;
        fire_req();
        build_exp(M_GEN, 0);
        wait_pkt(base, "R8");
        cmp_pkt("R8", 1'b0);
        wait_pkt(base + 1, "R8");
        cmp_pkt("R8", 1'b1);
        chk(ncr_pending == 2'b00, "R8", "flags cleared", ncr_pending, 0);
        queued = 2'b11;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule